// File: doc/BRIEF.md
# Pseudo-Random Bit Error Rate Receiver

This block checks a received serial bit stream against a pseudo-random reference sequence that it generates locally. It gains sync by loading its reference register from the incoming bits. It then checks a fixed run of predicted bits and declares lock only if those bits carry few enough errors. Once locked, it compares every qualified bit against the reference. It drops lock and acquires again when errors inside a fixed-size window pass a programmable limit. An inverted incoming stream is detected during acquisition and corrected, so an inverted link counts as error-free.

While a test runs, the block keeps these tallies: compared bits, errored bits, errors split by direction, one-second periods, seconds that held at least one error, and sync slips. A test starts on a start pulse, which clears the tallies. It ends by itself when the compared-bit count reaches a programmable test length. The surrounding system supplies the bit qualifier, the one-second tick and the thresholds, and it reads the tallies. Ratios and any presentation of the tallies belong to other blocks.

Top module: `ber_rx_monitor`

## Requirements
- R1: The reference sequence obeys b[n] = b[n-7] XOR b[n-6] (register length 7, tap 6 by default). Acquisition takes 7 qualified bits into the reference register and then checks the next 64 predicted bits. `locked` goes high after the edge that takes the 64th checked bit if that run held at most `allowThresh` errors.
- R2: When a 64-bit check fails, the polarity in use is toggled and loading starts again. A fully inverted stream therefore locks with `inverted` = 1 and counts no errors.
- R3: While locked, each qualified bit that takes the error count of the current 1024-bit window above `resyncThresh` does three things: it adds one to `slipCount`, it drops `locked` on that edge, and it restarts loading. The window count clears after every 1024 locked bits.
- R4: A `testStart` pulse clears every tally and sets `testRunning`. Tallies change only while `testRunning` is 1, and bits count only when `locked` is 1 and `bitValid` is 1.
- R5: `errCount` counts compared bits whose polarity-corrected value differs from the reference.
- R6: `oneAsZeroCount` counts errors where the reference was 1 and the corrected bit was 0. `zeroAsOneCount` counts the opposite case. The two always add up to `errCount`.
- R7: Each `secTick` adds one to `secondCount`. It also adds one to `erroredSecCount` if a counted error fell in any cycle after the previous tick, up to and including the cycle of the tick itself.
- R8: When `bitCount` reaches `testLength`, which must be nonzero, `testRunning` falls and `testDone` rises on that same edge. No further bits are counted until the next `testStart`.
- R9: A cycle with `bitValid` = 0 leaves the sync state, the reference and every tally unchanged.
- R10: After reset, `locked`, `inverted`, `testRunning` and `testDone` are 0 and every tally is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Qualifies `rxBit` this cycle |
| rxBit | input | 1 | Received data bit |
| secTick | input | 1 | One-cycle pulse once per second |
| testStart | input | 1 | Clears tallies and starts a test |
| testLength | input | 40 | Number of compared bits that ends the test |
| allowThresh | input | 11 | Largest error count accepted in the 64-bit acquisition check |
| resyncThresh | input | 11 | Window error count above which sync is dropped |
| locked | output | 1 | Sync held |
| inverted | output | 1 | Incoming stream is being inverted before comparison |
| testRunning | output | 1 | Test in progress |
| testDone | output | 1 | Test length reached |
| bitCount | output | 40 | Compared bits |
| errCount | output | 32 | Errored bits |
| oneAsZeroCount | output | 32 | Errors with reference 1, received 0 |
| zeroAsOneCount | output | 32 | Errors with reference 0, received 1 |
| secondCount | output | 32 | Seconds elapsed in test |
| erroredSecCount | output | 32 | Seconds containing an error |
| slipCount | output | 32 | Sync losses in test |

## Verification
The bench targets an inverted stream that arrives while the block is locked. A design that keeps its polarity after a failed check would never lock again, and a design that toggles at the wrong moment would lock with errors counted. Scattered single errors that stay under the window limit test the window clearing: a window that never clears would report slips that should not exist. A dense burst tests slip counting and the drop of `locked` on the exact edge. A short test length tests the stop: a block that counts past the limit, or stops one bit early, leaves the wrong `bitCount`. Gaps in `bitValid` and once-per-second ticks, some with errors and some without, test the gating and the errored-second flag, which must clear at each tick.

// File: rtl/ber_pkg.sv
package ber_pkg;

  typedef enum logic [1:0] {
    SYNC_LOAD   = 2'd0,
    SYNC_VERIFY = 2'd1,
    SYNC_LOCK   = 2'd2
  } syncState_t;

  // Strobes from the sync control to the datapath, valid in the current cycle
  typedef struct packed {
    logic loadEn;    // shift corrected received bit into reference
    logic runEn;     // advance reference on its own feedback, compare
    logic countEn;   // compared bit belongs to the statistics
    logic slipPulse; // sync dropped this cycle
    logic invert;    // polarity correction in use
  } syncStrobes_t;

endpackage

// File: rtl/ber_sync_ctrl.sv
module ber_sync_ctrl
  import ber_pkg::*;
#(
  parameter int LFSR_LEN   = 7,
  parameter int VERIFY_LEN = 64,
  parameter int WINDOW_LEN = 1024,
  parameter int THR_W      = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitErr,
  input  logic [THR_W-1:0] allowThresh,
  input  logic [THR_W-1:0] resyncThresh,
  output syncStrobes_t     strobes,
  output logic             locked,
  output logic             inverted
);

  localparam int LOAD_W = $clog2(LFSR_LEN);
  localparam int VCNT_W = $clog2(VERIFY_LEN);
  localparam int VERR_W = $clog2(VERIFY_LEN + 1);
  localparam int WCNT_W = $clog2(WINDOW_LEN);
  localparam int WERR_W = $clog2(WINDOW_LEN + 1);
  localparam logic [LOAD_W-1:0] LOAD_LAST = LOAD_W'(LFSR_LEN - 1);
  localparam logic [VCNT_W-1:0] VER_LAST  = VCNT_W'(VERIFY_LEN - 1);
  localparam logic [WCNT_W-1:0] WIN_LAST  = WCNT_W'(WINDOW_LEN - 1);

  syncState_t        state;
  logic [LOAD_W-1:0] loadCnt;
  logic [VCNT_W-1:0] verCnt;
  logic [VERR_W-1:0] verErr;
  logic [WCNT_W-1:0] winCnt;
  logic [WERR_W-1:0] winErr;
  logic              invReg;

  logic [VERR_W-1:0] verErrNext;
  logic [WERR_W:0]   winErrNext;
  logic              overLimit;

  assign verErrNext = verErr + VERR_W'(bitErr);
  assign winErrNext = {1'b0, winErr} + (WERR_W + 1)'(bitErr);
  assign overLimit  = 32'(winErrNext) > 32'(resyncThresh);

  always_comb begin
    strobes.loadEn    = bitValid && (state == SYNC_LOAD);
    strobes.runEn     = bitValid && (state != SYNC_LOAD);
    strobes.countEn   = bitValid && (state == SYNC_LOCK);
    strobes.slipPulse = bitValid && (state == SYNC_LOCK) && overLimit;
    strobes.invert    = invReg;
  end

  assign locked   = (state == SYNC_LOCK);
  assign inverted = invReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SYNC_LOAD;
      loadCnt <= '0;
      verCnt  <= '0;
      verErr  <= '0;
      winCnt  <= '0;
      winErr  <= '0;
      invReg  <= 1'b0;
    end else if (bitValid) begin
      unique case (state)
        SYNC_LOAD: begin
          if (loadCnt == LOAD_LAST) begin
            state   <= SYNC_VERIFY;
            loadCnt <= '0;
            verCnt  <= '0;
            verErr  <= '0;
          end else begin
            loadCnt <= loadCnt + 1'b1;
          end
        end
        SYNC_VERIFY: begin
          if (verCnt == VER_LAST) begin
            verCnt <= '0;
            if (32'(verErrNext) <= 32'(allowThresh)) begin
              state  <= SYNC_LOCK;
              winCnt <= '0;
              winErr <= '0;
            end else begin
              invReg <= ~invReg;
              state  <= SYNC_LOAD;
            end
          end else begin
            verCnt <= verCnt + 1'b1;
            verErr <= verErrNext;
          end
        end
        SYNC_LOCK: begin
          if (overLimit) begin
            state   <= SYNC_LOAD;
            loadCnt <= '0;
          end else if (winCnt == WIN_LAST) begin
            winCnt <= '0;
            winErr <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
            winErr <= winErrNext[WERR_W-1:0];
          end
        end
        default: state <= SYNC_LOAD;
      endcase
    end
  end

  // Lock is entered only from the checking phase (R1)
  p_lock_from_verify_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(state) == SYNC_VERIFY);

  // Polarity changes only as the result of a failed check (R2)
  p_polarity_on_fail_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(invReg) |-> ($past(state) == SYNC_VERIFY && state == SYNC_LOAD));

  // A slip always removes lock on the next cycle (R3)
  p_slip_unlocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.slipPulse |=> !locked);

  // Idle cycles leave sync state alone (R9)
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> ($stable(state) && $stable(invReg)));

endmodule

// File: rtl/ber_stats_dp.sv
module ber_stats_dp
  import ber_pkg::*;
#(
  parameter int LFSR_LEN = 7,
  parameter int LFSR_TAP = 6,
  parameter int BIT_W    = 40,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic             secTick,
  input  logic             testStart,
  input  logic [BIT_W-1:0] testLength,
  input  syncStrobes_t     strobes,
  output logic             bitErr,
  output logic             testRunning,
  output logic             testDone,
  output logic [BIT_W-1:0] bitCount,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] oneAsZeroCount,
  output logic [CNT_W-1:0] zeroAsOneCount,
  output logic [CNT_W-1:0] secondCount,
  output logic [CNT_W-1:0] erroredSecCount,
  output logic [CNT_W-1:0] slipCount
);

  logic [LFSR_LEN-1:0] refReg;
  logic refNext;
  logic gotBit;
  logic tallyHit;
  logic errHit;
  logic errSeen;

  assign refNext  = refReg[LFSR_LEN-1] ^ refReg[LFSR_TAP-1];
  assign gotBit   = rxBit ^ strobes.invert;
  assign bitErr   = strobes.runEn && (gotBit != refNext);
  assign tallyHit = strobes.countEn && testRunning;
  assign errHit   = tallyHit && bitErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refReg <= '0;
    end else if (strobes.loadEn) begin
      refReg <= {refReg[LFSR_LEN-2:0], gotBit};
    end else if (strobes.runEn) begin
      refReg <= {refReg[LFSR_LEN-2:0], refNext};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testRunning     <= 1'b0;
      testDone        <= 1'b0;
      bitCount        <= '0;
      errCount        <= '0;
      secondCount     <= '0;
      erroredSecCount <= '0;
      slipCount       <= '0;
      errSeen         <= 1'b0;
    end else if (testStart) begin
      testRunning     <= 1'b1;
      testDone        <= 1'b0;
      bitCount        <= '0;
      errCount        <= '0;
      secondCount     <= '0;
      erroredSecCount <= '0;
      slipCount       <= '0;
      errSeen         <= 1'b0;
    end else begin
      if (tallyHit) begin
        bitCount <= bitCount + 1'b1;
        if (bitCount + BIT_W'(1) == testLength) begin
          testRunning <= 1'b0;
          testDone    <= 1'b1;
        end
      end
      if (errHit) errCount <= errCount + 1'b1;
      if (strobes.slipPulse && testRunning) slipCount <= slipCount + 1'b1;
      if (secTick && testRunning) begin
        secondCount <= secondCount + 1'b1;
        if (errSeen || errHit) erroredSecCount <= erroredSecCount + 1'b1;
        errSeen <= 1'b0;
      end else if (errHit) begin
        errSeen <= 1'b1;
      end
    end
  end

  // One counter per expected-bit value: index 1 counts 1 seen as 0
  for (genvar gi = 0; gi < 2; gi++) begin : g_dir
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN || testStart) begin
        cnt <= '0;
      end else if (errHit && (refNext == gi[0])) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign oneAsZeroCount = g_dir[1].cnt;
  assign zeroAsOneCount = g_dir[0].cnt;

  // Direction tallies add up to the error tally (R6)
  p_split_sum_r6: assert property (@(posedge clk) disable iff (!rstN)
    errCount == CNT_W'(g_dir[0].cnt + g_dir[1].cnt));

  // Errored seconds never outnumber seconds (R7)
  p_errsec_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    erroredSecCount <= secondCount);

  // Stopped test freezes the bit tally (R8)
  p_frozen_stopped_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!testRunning && !testStart) |=> $stable(bitCount));

  // Reaching the length ends the test on that edge (R8)
  p_length_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tallyHit && !testStart && (bitCount + BIT_W'(1) == testLength)) |=> (testDone && !testRunning));

endmodule

// File: rtl/ber_rx_monitor.sv
module ber_rx_monitor
  import ber_pkg::*;
#(
  parameter int LFSR_LEN   = 7,
  parameter int LFSR_TAP   = 6,
  parameter int VERIFY_LEN = 64,
  parameter int WINDOW_LEN = 1024,
  parameter int THR_W      = 11,
  parameter int BIT_W      = 40,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             rxBit,
  input  logic             secTick,
  input  logic             testStart,
  input  logic [BIT_W-1:0] testLength,
  input  logic [THR_W-1:0] allowThresh,
  input  logic [THR_W-1:0] resyncThresh,
  output logic             locked,
  output logic             inverted,
  output logic             testRunning,
  output logic             testDone,
  output logic [BIT_W-1:0] bitCount,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] oneAsZeroCount,
  output logic [CNT_W-1:0] zeroAsOneCount,
  output logic [CNT_W-1:0] secondCount,
  output logic [CNT_W-1:0] erroredSecCount,
  output logic [CNT_W-1:0] slipCount
);

  syncStrobes_t strobes;
  logic         bitErr;

  ber_sync_ctrl #(
    .LFSR_LEN  (LFSR_LEN),
    .VERIFY_LEN(VERIFY_LEN),
    .WINDOW_LEN(WINDOW_LEN),
    .THR_W     (THR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bitValid    (bitValid),
    .bitErr      (bitErr),
    .allowThresh (allowThresh),
    .resyncThresh(resyncThresh),
    .strobes     (strobes),
    .locked      (locked),
    .inverted    (inverted)
  );

  ber_stats_dp #(
    .LFSR_LEN(LFSR_LEN),
    .LFSR_TAP(LFSR_TAP),
    .BIT_W   (BIT_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .rxBit          (rxBit),
    .secTick        (secTick),
    .testStart      (testStart),
    .testLength     (testLength),
    .strobes        (strobes),
    .bitErr         (bitErr),
    .testRunning    (testRunning),
    .testDone       (testDone),
    .bitCount       (bitCount),
    .errCount       (errCount),
    .oneAsZeroCount (oneAsZeroCount),
    .zeroAsOneCount (zeroAsOneCount),
    .secondCount    (secondCount),
    .erroredSecCount(erroredSecCount),
    .slipCount      (slipCount)
  );

endmodule

// File: tb/tb_ber_rx_monitor.sv
`timescale 1ns/1ps
module tb_ber_rx_monitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitValid = 1'b0;
  logic        rxBit = 1'b0;
  logic        secTick = 1'b0;
  logic        testStart = 1'b0;
  logic [39:0] testLength = 40'd1000000;
  logic [10:0] allowThresh = 11'd4;
  logic [10:0] resyncThresh = 11'd8;
  logic        locked, inverted, testRunning, testDone;
  logic [39:0] bitCount;
  logic [31:0] errCount, oneAsZeroCount, zeroAsOneCount;
  logic [31:0] secondCount, erroredSecCount, slipCount;

  always #4 clk = ~clk;

  ber_rx_monitor dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .secTick(secTick), .testStart(testStart), .testLength(testLength),
    .allowThresh(allowThresh), .resyncThresh(resyncThresh),
    .locked(locked), .inverted(inverted), .testRunning(testRunning),
    .testDone(testDone), .bitCount(bitCount), .errCount(errCount),
    .oneAsZeroCount(oneAsZeroCount), .zeroAsOneCount(zeroAsOneCount),
    .secondCount(secondCount), .erroredSecCount(erroredSecCount),
    .slipCount(slipCount)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic check(string tag, string name, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int     mPhase;       // 0 load, 1 check, 2 locked
  int     mCnt, mErr, wCnt, wErr;
  bit     mInv;
  bit     mRef[$];
  bit     mRun, mDone, mErrSeen;
  longint mBits, mErrs, mOneZero, mZeroOne, mSecs, mErrSecs, mSlips;

  always @(posedge clk) begin
    bit got, pred, e, counted, slip;
    e = 0; counted = 0; slip = 0;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mErr = 0; wCnt = 0; wErr = 0; mInv = 0;
      mRef = '{0, 0, 0, 0, 0, 0, 0};
      mRun = 0; mDone = 0; mErrSeen = 0;
      mBits = 0; mErrs = 0; mOneZero = 0; mZeroOne = 0;
      mSecs = 0; mErrSecs = 0; mSlips = 0;
    end else begin
      pred = mRef[0] ^ mRef[1];
      if (bitValid) begin
        got = rxBit ^ mInv;
        if (mPhase == 0) begin
          mRef.push_back(got); void'(mRef.pop_front());
          mCnt++;
          if (mCnt == 7) begin mPhase = 1; mCnt = 0; mErr = 0; end
        end else begin
          e = (got != pred);
          mRef.push_back(pred); void'(mRef.pop_front());
          if (mPhase == 1) begin
            mErr += int'(e); mCnt++;
            if (mCnt == 64) begin
              if (mErr <= int'(allowThresh)) begin mPhase = 2; wCnt = 0; wErr = 0; end
              else begin mInv = ~mInv; mPhase = 0; end
              mCnt = 0;
            end
          end else begin
            counted = 1;
            wErr += int'(e);
            if (wErr > int'(resyncThresh)) begin slip = 1; mPhase = 0; mCnt = 0; end
            else begin
              wCnt++;
              if (wCnt == 1024) begin wCnt = 0; wErr = 0; end
            end
          end
        end
      end
      if (testStart) begin
        mRun = 1; mDone = 0; mErrSeen = 0;
        mBits = 0; mErrs = 0; mOneZero = 0; mZeroOne = 0;
        mSecs = 0; mErrSecs = 0; mSlips = 0;
      end else begin
        bit hitErr;
        hitErr = counted && mRun && e;
        if (slip && mRun) mSlips++;
        if (secTick && mRun) begin
          mSecs++;
          if (mErrSeen || hitErr) mErrSecs++;
          mErrSeen = 0;
        end else if (hitErr) mErrSeen = 1;
        if (counted && mRun) begin
          mBits++;
          if (e) begin
            mErrs++;
            if (pred) mOneZero++; else mZeroOne++;
          end
          if (mBits == longint'(testLength)) begin mRun = 0; mDone = 1; end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1", "locked", longint'(locked), longint'(mPhase == 2));
      check("R2", "inverted", longint'(inverted), longint'(mInv));
      check("R3", "slipCount", longint'(slipCount), mSlips);
      check("R4", "testRunning", longint'(testRunning), longint'(mRun));
      check("R4", "bitCount", longint'(bitCount), mBits);
      check("R5", "errCount", longint'(errCount), mErrs);
      check("R6", "oneAsZeroCount", longint'(oneAsZeroCount), mOneZero);
      check("R6", "zeroAsOneCount", longint'(zeroAsOneCount), mZeroOne);
      check("R7", "secondCount", longint'(secondCount), mSecs);
      check("R7", "erroredSecCount", longint'(erroredSecCount), mErrSecs);
      check("R8", "testDone", longint'(testDone), longint'(mDone));
    end
  end

  // ---------------- stimulus ----------------
  bit txHist[$] = '{1, 1, 1, 1, 1, 1, 1};

  function automatic bit nextPrbs();
    bit nb;
    nb = txHist[0] ^ txHist[1];
    txHist.push_back(nb); void'(txHist.pop_front());
    return nb;
  endfunction

  // n qualified bits; flipEvery>0 corrupts every flipEvery-th bit; gaps idles every 5th cycle (R9)
  task automatic sendBits(int n, bit invStream, int flipEvery, bit gaps);
    int sent = 0;
    int cyc = 0;
    while (sent < n) begin
      @(negedge clk);
      cyc++;
      if (gaps && (cyc % 5 == 0)) begin
        bitValid = 1'b0;
        rxBit = ~rxBit;
      end else begin
        bit b;
        b = nextPrbs();
        if (flipEvery > 0 && (sent % flipEvery == flipEvery - 1)) b = ~b;
        rxBit = b ^ invStream;
        bitValid = 1'b1;
        sent++;
      end
    end
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic pulseStart(longint len);
    @(negedge clk);
    testLength = 40'(len);
    testStart = 1'b1;
    @(negedge clk);
    testStart = 1'b0;
  endtask

  // One-second tick every 97 cycles
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      secTick = (rstN && (t % 97 == 0));
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "locked after reset", longint'(locked), 0);
    check("R10", "bitCount after reset", longint'(bitCount), 0);
    check("R10", "testRunning after reset", longint'(testRunning), 0);
    check("R10", "slipCount after reset", longint'(slipCount), 0);

    pulseStart(1000000);
    sendBits(300, 1'b0, 0, 1'b0);
    check("R1", "locked on clean stream", longint'(locked), 1);
    check("R5", "no errors on clean stream", longint'(errCount), 0);

    // Scattered errors below the window limit, with idle gaps (R3, R9)
    sendBits(2500, 1'b0, 150, 1'b1);
    check("R3", "no slip below limit", longint'(slipCount), 0);
    check("R5", "scattered errors seen", longint'(errCount > 0), 1);

    // Dense burst forces a slip, then clean bits reacquire (R3)
    sendBits(40, 1'b0, 1, 1'b0);
    sendBits(400, 1'b0, 0, 1'b0);
    check("R3", "slip after burst", longint'(slipCount >= 1), 1);
    check("R3", "relocked after burst", longint'(locked), 1);

    // Stream switches to inverted (R2)
    sendBits(600, 1'b1, 0, 1'b0);
    check("R2", "inverted stream corrected", longint'(inverted), 1);
    check("R2", "inverted stream locked", longint'(locked), 1);

    // Short test ends on its length (R8)
    pulseStart(500);
    sendBits(800, 1'b1, 0, 1'b0);
    check("R8", "test done", longint'(testDone), 1);
    check("R8", "bits stop at length", longint'(bitCount), 500);
    check("R5", "inverted stream error-free", longint'(errCount), 0);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule